// File: doc/BRIEF.md
# Configurable Codec Serial Word Shifter

This block moves one data word at a time between a parallel word and a serial codec line. It runs entirely in the system clock domain. A separate bit clock source supplies it with single-cycle pulses that mark the rising and falling transitions of the serial clock. One of those transitions is used to capture incoming data and the other to advance outgoing data. A control bit selects which transition captures.

The word length depends on a 2-bit protocol field and a 4-bit size field. In the multi-channel and I2S protocols the size field sets a length of 4 to 16 bits. The two link protocols fix the slot at 16 or 20 bits and ignore the size field. A frame-start strobe marks the first bit of a frame. It loads the transmit word and restarts reception. When the last bit has been captured, the block presents the received word right-justified and pulses a completion strobe. It then reloads the transmit word, so words follow each other with no gap. Frame sync generation, slot counting across a frame and any buffering belong to the surrounding logic.

Top module: `codec_word_shifter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is sampled low, `sdo` is 0, `rx_word` is 0 and `word_done` is 0.
- R2: For protocol values 2'b00 (multi-channel) and 2'b01 (I2S), the word length is `word_size` + 1 bits whenever `word_size` is 3 or more.
- R3: In protocols 2'b00 and 2'b01, `word_size` values 0, 1 and 2 give a 4-bit word.
- R4: Protocol 2'b10 gives a 16-bit word and protocol 2'b11 gives a 20-bit word, whatever the value of `word_size`.
- R5: With `sample_rising` at 0, data is captured on `bclk_fall` pulses and output advances on `bclk_rise` pulses. With `sample_rising` at 1 the two roles swap.
- R6: Data goes out MSB first. After a word is loaded, `sdo` carries bit length-1 of `tx_word`. Each advance pulse that comes after at least one capture in the current word moves `sdo` to the next lower bit. Advance pulses that come before the first capture of a word leave `sdo` unchanged.
- R7: `frame_start` loads `tx_word`, clears the received-bit count and discards any partly received bits.
- R8: When the last bit of a word is captured, `word_done` is high for exactly one system clock in the following cycle. In that same cycle `rx_word` holds the word right-justified, with zeros above the word length. `rx_word` changes at no other time.
- R9: When a word completes without a `frame_start`, the next word starts at once. `tx_word` is reloaded and the bit count starts again from zero.
- R10: When `frame_start` arrives in the same cycle as an edge pulse, `frame_start` wins and the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_rise | input | 1 | One-cycle pulse at a rising serial clock transition |
| bclk_fall | input | 1 | One-cycle pulse at a falling serial clock transition |
| frame_start | input | 1 | Frame start strobe |
| word_size | input | WS_W (4) | Word length minus one (multi-channel and I2S) |
| proto_mode | input | 2 | 00 multi-channel, 01 I2S, 10 16-bit link, 11 20-bit link |
| sample_rising | input | 1 | 1: capture on rising transition, 0: capture on falling transition |
| sdi | input | 1 | Serial data in |
| tx_word | input | MAX_LEN (20) | Parallel word to transmit, right-justified |
| sdo | output | 1 | Serial data out |
| rx_word | output | MAX_LEN (20) | Last received word, right-justified |
| word_done | output | 1 | One-cycle word completion strobe |

## Verification
The assertions assume the following about the inputs:
- Each edge pulse lasts one cycle.
- Rising and falling pulses never coincide.
- `proto_mode`, `word_size` and `sample_rising` stay steady from a word's load until its completion.
- An advance pulse never lands in the same cycle as a word's final capture.

The stimulus keeps to these rules. It always separates a capture pulse from the following advance pulse by an idle cycle. It changes the configuration only just before a `frame_start`. The one deliberate overlap is a `frame_start` issued together with a capture pulse, which tests the priority rule.

// File: rtl/cws_pkg.sv
// Package: shared protocol codes and fixed slot widths for the codec
// word shifter. Assumes no tool-specific features.
package cws_pkg;
    typedef enum logic [1:0] {
        PROTO_MULTI  = 2'b00,
        PROTO_I2S    = 2'b01,
        PROTO_LINK16 = 2'b10,
        PROTO_LINK20 = 2'b11
    } cws_proto_e;

    localparam int LINK_SHORT_LEN = 16;
    localparam int LINK_LONG_LEN  = 20;
    localparam int MIN_WORD_LEN   = 4;
endpackage

// File: rtl/cws_len_decode.sv
// Module: cws_len_decode
// Turns protocol and size fields into the active word length.
// Assumes CNT_W is wide enough to hold the longest slot and WS_W < CNT_W.
module cws_len_decode
    import cws_pkg::*;
#(
    parameter int WS_W  = 4,
    parameter int CNT_W = 5
) (
    input  logic [WS_W-1:0]  word_size,
    input  logic [1:0]       proto_mode,
    output logic [CNT_W-1:0] word_len
);
    logic [CNT_W-1:0] size_len;

    // Size field encodes length minus one; short values floor at the minimum
    always_comb begin
        size_len = CNT_W'(word_size) + CNT_W'(1);
        if (size_len < CNT_W'(MIN_WORD_LEN))
            size_len = CNT_W'(MIN_WORD_LEN);
    end

    // Link protocols force fixed slot widths and ignore the size field
    always_comb begin
        unique case (cws_proto_e'(proto_mode))
            PROTO_LINK16: word_len = CNT_W'(LINK_SHORT_LEN);
            PROTO_LINK20: word_len = CNT_W'(LINK_LONG_LEN);
            default:      word_len = size_len;
        endcase
    end
endmodule

// File: rtl/cws_edge_sel.sv
// Module: cws_edge_sel
// Routes bit clock edge pulses to the capture role or the advance role.
// Assumes the pulses are already synchronous one-cycle strobes.
module cws_edge_sel (
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic sample_rising,
    output logic sample_pulse,
    output logic drive_pulse
);
    // The capture edge is selected; the opposite edge advances output
    always_comb begin
        sample_pulse = sample_rising ? bclk_rise : bclk_fall;
        drive_pulse  = sample_rising ? bclk_fall : bclk_rise;
    end
endmodule

// File: rtl/cws_rx_assembler.sv
// Module: cws_rx_assembler
// Counts captured bits and shifts sdi in. When the count reaches the
// word length it publishes a right-justified word and a done strobe.
// Assumes word_len stays steady within a word.
module cws_rx_assembler #(
    parameter int MAX_LEN = 20,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               sample_pulse,
    input  logic               sdi,
    input  logic [CNT_W-1:0]   word_len,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               word_end,
    output logic [MAX_LEN-1:0] rx_word,
    output logic               word_done
);
    logic [MAX_LEN-1:0] rx_sr;
    logic [MAX_LEN-1:0] rx_next;

    // Last bit of the word is being captured this cycle
    always_comb begin
        rx_next  = {rx_sr[MAX_LEN-2:0], sdi};
        word_end = sample_pulse && !frame_start &&
                   (bit_cnt == word_len - CNT_W'(1));
    end

    // Shift register, bit counter and published word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr     <= '0;
            bit_cnt   <= '0;
            rx_word   <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (frame_start) begin
                rx_sr   <= '0;
                bit_cnt <= '0;
            end else if (word_end) begin
                rx_word   <= rx_next;
                word_done <= 1'b1;
                rx_sr     <= '0;
                bit_cnt   <= '0;
            end else if (sample_pulse) begin
                rx_sr   <= rx_next;
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cws_tx_shifter.sv
// Module: cws_tx_shifter
// Left-aligns the transmit word at each load and shifts it out MSB first.
// Shifts only once the current word has at least one captured bit.
// Assumes a word_end load never coincides with an advance pulse.
module cws_tx_shifter #(
    parameter int MAX_LEN = 20,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               drive_pulse,
    input  logic               word_active,
    input  logic [CNT_W-1:0]   word_len,
    input  logic [MAX_LEN-1:0] tx_word,
    output logic               sdo
);
    localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_LEN);

    logic [MAX_LEN-1:0] tx_sr;
    logic [CNT_W-1:0]   align_sh;

    // Shift that puts bit word_len-1 at the top of the register
    always_comb align_sh = MAX_L - word_len;

    // Load has priority over advance; advance waits for the first capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (load)
            tx_sr <= tx_word << align_sh;
        else if (drive_pulse && word_active)
            tx_sr <= {tx_sr[MAX_LEN-2:0], 1'b0};
    end

    assign sdo = tx_sr[MAX_LEN-1];
endmodule

// File: rtl/codec_word_shifter.sv
// Module: codec_word_shifter (top)
// Serial word shifter for a codec link with programmable length and
// capture edge. Assumes edge pulses arrive in the clk domain and the
// configuration stays steady within a word. MAX_LEN must be at least 20.
module codec_word_shifter #(
    parameter int WS_W    = 4,
    parameter int MAX_LEN = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bclk_rise,
    input  logic               bclk_fall,
    input  logic               frame_start,
    input  logic [WS_W-1:0]    word_size,
    input  logic [1:0]         proto_mode,
    input  logic               sample_rising,
    input  logic               sdi,
    input  logic [MAX_LEN-1:0] tx_word,
    output logic               sdo,
    output logic [MAX_LEN-1:0] rx_word,
    output logic               word_done
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] word_len;
    logic [CNT_W-1:0] bit_cnt;
    logic             sample_pulse;
    logic             drive_pulse;
    logic             word_end;
    logic             tx_load;
    logic             word_active;

    cws_len_decode #(.WS_W(WS_W), .CNT_W(CNT_W)) u_len (
        .word_size (word_size),
        .proto_mode(proto_mode),
        .word_len  (word_len)
    );

    cws_edge_sel u_edge (
        .bclk_rise    (bclk_rise),
        .bclk_fall    (bclk_fall),
        .sample_rising(sample_rising),
        .sample_pulse (sample_pulse),
        .drive_pulse  (drive_pulse)
    );

    cws_rx_assembler #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .sample_pulse(sample_pulse),
        .sdi         (sdi),
        .word_len    (word_len),
        .bit_cnt     (bit_cnt),
        .word_end    (word_end),
        .rx_word     (rx_word),
        .word_done   (word_done)
    );

    // Transmit reloads at frame start and at every word completion
    always_comb begin
        tx_load     = frame_start || word_end;
        word_active = (bit_cnt != '0);
    end

    cws_tx_shifter #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tx_load),
        .drive_pulse(drive_pulse),
        .word_active(word_active),
        .word_len   (word_len),
        .tx_word    (tx_word),
        .sdo        (sdo)
    );
endmodule

// File: rtl/cws_checker.sv
// Module: cws_checker
// Port-level properties of codec_word_shifter, attached by bind.
// Assumes the input rules listed in the brief.
module cws_checker #(
    parameter int WS_W    = 4,
    parameter int MAX_LEN = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bclk_rise,
    input logic               bclk_fall,
    input logic               frame_start,
    input logic [WS_W-1:0]    word_size,
    input logic [1:0]         proto_mode,
    input logic               sample_rising,
    input logic [MAX_LEN-1:0] tx_word,
    input logic               sdo,
    input logic [MAX_LEN-1:0] rx_word,
    input logic               word_done
);
    int                 chk_len;
    logic [MAX_LEN-1:0] len_mask;
    logic               msb_exp;

    // Expected length, mask and first output bit from the requirements
    always_comb begin
        if (proto_mode == 2'b10)      chk_len = 16;
        else if (proto_mode == 2'b11) chk_len = 20;
        else if (int'(word_size) < 3) chk_len = 4;
        else                          chk_len = int'(word_size) + 1;
        len_mask = (MAX_LEN'(1) << chk_len) - MAX_LEN'(1);
        msb_exp  = tx_word[chk_len-1];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sdo == 1'b0 && rx_word == '0 && !word_done));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    // R8
    rx_justify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> ((rx_word & ~len_mask) == '0));

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |-> $stable(rx_word));

    // R5
    done_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(sample_rising ? bclk_rise : bclk_fall));

    // R7
    frame_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !word_done);

    // R6
    frame_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (sdo == $past(msb_exp)));
endmodule

bind codec_word_shifter cws_checker #(.WS_W(WS_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_rise    (bclk_rise),
    .bclk_fall    (bclk_fall),
    .frame_start  (frame_start),
    .word_size    (word_size),
    .proto_mode   (proto_mode),
    .sample_rising(sample_rising),
    .tx_word      (tx_word),
    .sdo          (sdo),
    .rx_word      (rx_word),
    .word_done    (word_done)
);

// File: tb/codec_word_shifter_test.sv
// Bench: scoreboard driven. The driver queues expected receive words
// and the monitor pops them whenever word_done is seen.
module codec_word_shifter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_rise = 1'b0;
    logic        bclk_fall = 1'b0;
    logic        frame_start = 1'b0;
    logic [3:0]  word_size = 4'd0;
    logic [1:0]  proto_mode = 2'b00;
    logic        sample_rising = 1'b0;
    logic        sdi = 1'b0;
    logic [19:0] tx_word = '0;
    logic        sdo;
    logic [19:0] rx_word;
    logic        word_done;

    int checks = 0;
    int failures = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_word_shifter uut (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .frame_start(frame_start), .word_size(word_size), .proto_mode(proto_mode),
        .sample_rising(sample_rising), .sdi(sdi), .tx_word(tx_word),
        .sdo(sdo), .rx_word(rx_word), .word_done(word_done)
    );

    function automatic int exp_len(input logic [1:0] m, input logic [3:0] ws);
        if (m == 2'b10) return 16;
        if (m == 2'b11) return 20;
        if (ws < 4'd3) return 4;
        return int'(ws) + 1;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_sample();
        if (sample_rising) bclk_rise = 1'b1; else bclk_fall = 1'b1;
        @(negedge clk);
        bclk_rise = 1'b0; bclk_fall = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_drive();
        if (sample_rising) bclk_fall = 1'b1; else bclk_rise = 1'b1;
        @(negedge clk);
        bclk_rise = 1'b0; bclk_fall = 1'b0;
        @(negedge clk);
    endtask

    // Driver: one word, checking sdo bit by bit and queueing the receive word
    task automatic run_word(input bit do_frame, input logic [1:0] m, input logic [3:0] ws,
                            input logic re, input logic [19:0] txw, input logic [19:0] rxw,
                            input logic [19:0] next_tx, input string tag);
        int n;
        logic [19:0] mask;
        n = exp_len(m, ws);
        mask = (20'd1 << n) - 20'd1;
        if (do_frame) begin
            proto_mode = m; word_size = ws; sample_rising = re; tx_word = txw;
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            @(negedge clk);
        end
        pulse_drive();  // R6: no shift before the first capture
        for (int i = 0; i < n; i++) begin
            check(sdo == txw[n-1-i], $sformatf("R6 %s bit %0d", tag, i), 20'(sdo), 20'(txw[n-1-i]));
            if (i == n-1) begin
                tx_word = next_tx;
                exp_q.push_back(rxw & mask);
                tag_q.push_back(tag);
            end
            sdi = rxw[n-1-i];
            pulse_sample();
            pulse_drive();
        end
    endtask

    // Monitor: compare each completed word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && word_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected word_done", rx_word, 20'h0);
            end else begin
                automatic logic [19:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rx_word == e, $sformatf("R8 %s rx_word", t), rx_word, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sdo == 1'b0, "R1 sdo", 20'(sdo), 20'h0);
        check(rx_word == '0, "R1 rx_word", rx_word, 20'h0);
        check(word_done == 1'b0, "R1 word_done", 20'(word_done), 20'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 multi-channel 8 bits, falling capture
        run_word(1, 2'b00, 4'd7, 1'b0, 20'h000A5, 20'h0003C, 20'h0, "R2 mc8");
        // R5 I2S 16 bits, rising capture
        run_word(1, 2'b01, 4'd15, 1'b1, 20'h0BEEF, 20'h01234, 20'h0, "R5 i2s16");
        // R3 size field 1 gives 4 bits; upper tx bits must not appear
        run_word(1, 2'b00, 4'd1, 1'b0, 20'hFFFF9, 20'hFFFF6, 20'h0, "R3 short");
        // R4 link16 ignores size field
        run_word(1, 2'b10, 4'd2, 1'b0, 20'h0C0DE, 20'h08001, 20'h0, "R4 link16");
        // R4 link20 ignores size field
        run_word(1, 2'b11, 4'd5, 1'b1, 20'hABCDE, 20'h5A5A5, 20'h0, "R4 link20");
        // R9 back-to-back words without a new frame start
        run_word(1, 2'b00, 4'd4, 1'b0, 20'h00013, 20'h0000B, 20'h0000C, "R9 first");
        run_word(0, 2'b00, 4'd4, 1'b0, 20'h0000C, 20'h00015, 20'h0, "R9 second");

        // R7 partial word discarded by a new frame start
        proto_mode = 2'b00; word_size = 4'd5; sample_rising = 1'b0; tx_word = 20'h0002D;
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0; @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            sdi = 1'b1; pulse_sample(); pulse_drive();
        end
        run_word(1, 2'b00, 4'd5, 1'b0, 20'h00012, 20'h00009, 20'h0, "R7 restart");

        // R10 frame start beats a simultaneous capture pulse
        tx_word = 20'h000B4; proto_mode = 2'b00; word_size = 4'd7; sample_rising = 1'b0;
        frame_start = 1'b1; bclk_fall = 1'b1; sdi = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; bclk_fall = 1'b0;
        @(negedge clk);
        run_word(0, 2'b00, 4'd7, 1'b0, 20'h000B4, 20'h00042, 20'h0, "R10 priority");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 all queued words completed", 20'(exp_q.size()), 20'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule